// File: doc/BRIEF.md
# Set-Associative Tag Directory with Line Reservations

This block keeps the tags, permission states, replacement ages and context reservations of a set-associative cache, without any data array. A requester presents one operation per cycle: a line-aligned address, an opcode and, depending on the opcode, a request kind, a new permission or a context ID. One cycle later the block answers with a flag, an error bit, a way number, a line address and a permission value.

The set is chosen by the address bits directly above the line offset. Lookups compare the remaining upper bits against every way of that set in parallel. A line whose permission is "absent" is treated as a free slot. Victim choice uses exact least-recently-used ages, one age per way, held as a permutation of 0..WAYS-1 within each set.

Each line also carries a reservation that names one context or none. Allocation, removal and any change of permission wipe that reservation, so a context checking its reservation learns whether the line was disturbed.

Top module: `tag_directory`

## Requirements
- R1: Each cycle with `reqValid` high is answered on the next cycle with `rspValid` high, and `rspValid` is low after a cycle without a request. Opcodes: 0 access, 1 presence test, 2 room test, 3 allocate, 4 remove, 5 set permission, 6 victim probe, 7 reserve, 8 unreserve, 9 reservation check, 10 read permission. Any other code gives `rspError`.
- R2: Permission codes are 0 absent, 1 invalid, 2 read-only and 3 read-write. A line that is absent never matches for access, presence or the line-addressed operations, so a presence test on it returns flag 0.
- R3: Request kinds are 0 load, 1 fetch, 2 store and 3 atomic. An access returns flag 1 only when the tag matches and either the line is read-write, or the line is read-only and the kind is load or fetch. On a match `rspWay` is the matching way; without a match it is 0.
- R4: Every access that matches a tag makes that way most recent in its set, even when the access is refused. The touched way's age becomes 0 and every way younger than it ages by one.
- R5: The room test returns flag 1 when the address already matches a line of its set, or when any way of the set is empty or absent.
- R6: Allocate writes the lowest-numbered empty or absent way, returns it in `rspWay` with flag 1, leaves the line invalid with no reservation and marks it most recent. When the set has no free way, or the line already matches, the response is `rspError` and nothing changes.
- R7: Remove empties the matching way and drops its reservation. Afterwards the line no longer matches and the way is free again.
- R8: Reserve stores `reqCtx` in the matching line and unreserve stores none. The reservation check returns flag 1 only when a context is stored and it equals `reqCtx`.
- R9: Setting a permission writes `reqPerm` to the matching line and drops its reservation. Read-permission returns the stored code in `rspPerm`.
- R10: The victim probe on a full set returns flag 1, the way with the oldest age in `rspWay`, and that way's full line address in `rspAddr`, with zero offset bits. On a set that still has a free way the response is `rspError`.
- R11: After reset every way of every set is empty with no reservation, so presence tests miss and room tests succeed.
- R12: Sets are independent. An operation on one set leaves the contents and ages of every other set unchanged.
- R13: Remove, set permission, reserve, unreserve, reservation check and read permission on an address with no matching line return `rspError` with flag 0 and way 0, and change nothing. Outside access and read permission, `rspPerm` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Operation present this cycle |
| reqOp | input | 4 | Opcode |
| reqKind | input | 2 | Request kind for access |
| reqAddr | input | ADDR_W | Line-aligned address |
| reqPerm | input | 2 | New permission for set permission |
| reqCtx | input | CTX_W | Context for reserve and check |
| rspValid | output | 1 | Response present |
| rspFlag | output | 1 | Hit / true result of the operation |
| rspError | output | 1 | Operation refused |
| rspWay | output | log2(WAYS) | Matched, allocated or victim way |
| rspAddr | output | ADDR_W | Victim line address from a probe |
| rspPerm | output | 2 | Stored permission from read permission |

## Verification
The bench fills a set to capacity and then allocates once more, expecting an error. A design that ignored fullness would silently overwrite a live line. It refuses a store to a read-only line that a load to the same line would hit, and then probes. This catches a design that gates the LRU touch on the hit instead of on the tag match, because its victim would be the wrong way. It reserves lines and then changes their permission or reallocates them. A design that kept the reservation would answer the check with a stale 1. It also marks a line absent and expects both the room test and the next allocation to reuse that lowest way, which catches designs that treat only empty ways as free.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;

  typedef enum logic [3:0] {
    OP_ACCESS   = 4'd0,
    OP_PRESENT  = 4'd1,
    OP_ROOM     = 4'd2,
    OP_ALLOC    = 4'd3,
    OP_DROP     = 4'd4,
    OP_SETPERM  = 4'd5,
    OP_PROBE    = 4'd6,
    OP_RSV_SET  = 4'd7,
    OP_RSV_CLR  = 4'd8,
    OP_RSV_CHK  = 4'd9,
    OP_READPERM = 4'd10
  } dirOp_e;

  typedef enum logic [1:0] {
    PERM_ABSENT  = 2'd0,
    PERM_INVALID = 2'd1,
    PERM_RDONLY  = 2'd2,
    PERM_RDWR    = 2'd3
  } linePerm_e;

  typedef enum logic [1:0] {
    KIND_LOAD   = 2'd0,
    KIND_FETCH  = 2'd1,
    KIND_STORE  = 2'd2,
    KIND_ATOMIC = 2'd3
  } reqKind_e;

  // Write strobes from control to the storage datapath
  typedef struct packed {
    logic touch;
    logic alloc;
    logic drop;
    logic setPerm;
    logic rsvSet;
    logic rsvClr;
  } dirStrobe_t;

endpackage

// File: rtl/tagdir_store.sv
module tagdir_store
  import tagdir_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 6,
  parameter int SETS     = 8,
  parameter int WAYS     = 4,
  parameter int CTX_W    = 4,
  localparam int SET_W   = $clog2(SETS),
  localparam int WAY_W   = $clog2(WAYS),
  localparam int TAG_W   = ADDR_W - OFFSET_W - SET_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lookAddr,
  input  dirStrobe_t        strobe,
  input  logic [WAY_W-1:0]  wrWay,
  input  logic [1:0]        newPerm,
  input  logic [CTX_W-1:0]  newCtx,
  output logic [WAYS-1:0]   matchVec,
  output logic [WAYS-1:0]   freeVec,
  output logic [1:0]        wayPerm [WAYS],
  output logic [WAYS-1:0]   wayHeld,
  output logic [CTX_W-1:0]  wayCtx  [WAYS],
  output logic [WAY_W-1:0]  victimWay,
  output logic [TAG_W-1:0]  victimTag
);

  localparam logic [WAY_W-1:0] AGE_OLDEST = WAY_W'(WAYS - 1);

  logic              entValid [SETS][WAYS];
  logic [TAG_W-1:0]  entTag   [SETS][WAYS];
  logic [1:0]        entPerm  [SETS][WAYS];
  logic              entHeld  [SETS][WAYS];
  logic [CTX_W-1:0]  entCtx   [SETS][WAYS];
  logic [WAY_W-1:0]  entAge   [SETS][WAYS];

  logic [SET_W-1:0]  setIdx;
  logic [TAG_W-1:0]  tagIn;

  assign setIdx = lookAddr[OFFSET_W +: SET_W];
  assign tagIn  = lookAddr[ADDR_W-1 -: TAG_W];

  // Per-way view of the addressed set
  for (genvar w = 0; w < WAYS; w++) begin : g_view
    assign matchVec[w] = entValid[setIdx][w] && (entTag[setIdx][w] == tagIn)
                         && (entPerm[setIdx][w] != PERM_ABSENT);
    assign freeVec[w]  = !entValid[setIdx][w] || (entPerm[setIdx][w] == PERM_ABSENT);
    assign wayPerm[w]  = entPerm[setIdx][w];
    assign wayHeld[w]  = entHeld[setIdx][w];
    assign wayCtx[w]   = entCtx[setIdx][w];
  end

  // Oldest way: the one whose age equals WAYS-1
  always_comb begin
    victimWay = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (entAge[setIdx][w] == AGE_OLDEST) victimWay = WAY_W'(w);
    end
  end

  assign victimTag = entTag[setIdx][victimWay];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          entValid[s][w] <= 1'b0;
          entTag[s][w]   <= '0;
          entPerm[s][w]  <= PERM_ABSENT;
          entHeld[s][w]  <= 1'b0;
          entCtx[s][w]   <= '0;
          entAge[s][w]   <= WAY_W'(w);
        end
      end
    end else begin
      if (strobe.alloc) begin
        entValid[setIdx][wrWay] <= 1'b1;
        entTag[setIdx][wrWay]   <= tagIn;
        entPerm[setIdx][wrWay]  <= PERM_INVALID;
        entHeld[setIdx][wrWay]  <= 1'b0;
      end
      if (strobe.drop) begin
        entValid[setIdx][wrWay] <= 1'b0;
        entPerm[setIdx][wrWay]  <= PERM_ABSENT;
        entHeld[setIdx][wrWay]  <= 1'b0;
      end
      if (strobe.setPerm) begin
        entPerm[setIdx][wrWay]  <= newPerm;
        entHeld[setIdx][wrWay]  <= 1'b0;
      end
      if (strobe.rsvSet) begin
        entHeld[setIdx][wrWay]  <= 1'b1;
        entCtx[setIdx][wrWay]   <= newCtx;
      end
      if (strobe.rsvClr) begin
        entHeld[setIdx][wrWay]  <= 1'b0;
      end
      if (strobe.touch) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == wrWay) begin
            entAge[setIdx][w] <= '0;
          end else if (entAge[setIdx][w] < entAge[setIdx][wrWay]) begin
            entAge[setIdx][w] <= entAge[setIdx][w] + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/tagdir_ctrl.sv
module tagdir_ctrl
  import tagdir_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 6,
  parameter int SETS     = 8,
  parameter int WAYS     = 4,
  parameter int CTX_W    = 4,
  localparam int SET_W   = $clog2(SETS),
  localparam int WAY_W   = $clog2(WAYS),
  localparam int TAG_W   = ADDR_W - OFFSET_W - SET_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [3:0]        reqOp,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CTX_W-1:0]  reqCtx,
  input  logic [WAYS-1:0]   matchVec,
  input  logic [WAYS-1:0]   freeVec,
  input  logic [1:0]        wayPerm [WAYS],
  input  logic [WAYS-1:0]   wayHeld,
  input  logic [CTX_W-1:0]  wayCtx  [WAYS],
  input  logic [WAY_W-1:0]  victimWay,
  input  logic [TAG_W-1:0]  victimTag,
  output dirStrobe_t        strobe,
  output logic [WAY_W-1:0]  wrWay,
  output logic              rspValid,
  output logic              rspFlag,
  output logic              rspError,
  output logic [WAY_W-1:0]  rspWay,
  output logic [ADDR_W-1:0] rspAddr,
  output logic [1:0]        rspPerm
);

  dirOp_e            opE;
  logic              matchAny, freeAny;
  logic [WAY_W-1:0]  matchWay, freeWay;
  logic [1:0]        selPerm;
  logic              kindReads;
  logic              nFlag, nError;
  logic [WAY_W-1:0]  nWay;
  logic [ADDR_W-1:0] nAddr;
  logic [1:0]        nPerm;

  assign opE       = dirOp_e'(reqOp);
  assign kindReads = (reqKind == KIND_LOAD) || (reqKind == KIND_FETCH);

  // Lowest-index encoders for the matching and free ways
  always_comb begin
    matchAny = 1'b0;
    matchWay = '0;
    freeAny  = 1'b0;
    freeWay  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (matchVec[w]) begin
        matchAny = 1'b1;
        matchWay = WAY_W'(w);
      end
      if (freeVec[w]) begin
        freeAny = 1'b1;
        freeWay = WAY_W'(w);
      end
    end
  end

  assign selPerm = wayPerm[matchWay];

  always_comb begin
    strobe = '0;
    wrWay  = matchWay;
    nFlag  = 1'b0;
    nError = 1'b0;
    nWay   = '0;
    nAddr  = '0;
    nPerm  = '0;
    if (reqValid) begin
      unique case (opE)
        OP_ACCESS: begin
          if (matchAny) begin
            strobe.touch = 1'b1;
            nWay  = matchWay;
            nFlag = (selPerm == PERM_RDWR) || ((selPerm == PERM_RDONLY) && kindReads);
          end
        end
        OP_PRESENT: begin
          nFlag = matchAny;
          nWay  = matchAny ? matchWay : '0;
        end
        OP_ROOM: begin
          nFlag = matchAny || freeAny;
        end
        OP_ALLOC: begin
          if (matchAny || !freeAny) begin
            nError = 1'b1;
          end else begin
            strobe.alloc = 1'b1;
            strobe.touch = 1'b1;
            wrWay = freeWay;
            nWay  = freeWay;
            nFlag = 1'b1;
          end
        end
        OP_PROBE: begin
          if (freeAny) begin
            nError = 1'b1;
          end else begin
            nFlag = 1'b1;
            nWay  = victimWay;
            nAddr = {victimTag, reqAddr[OFFSET_W +: SET_W], {OFFSET_W{1'b0}}};
          end
        end
        OP_DROP, OP_SETPERM, OP_RSV_SET, OP_RSV_CLR, OP_RSV_CHK, OP_READPERM: begin
          if (!matchAny) begin
            nError = 1'b1;
          end else begin
            nWay = matchWay;
            case (opE)
              OP_DROP:     begin strobe.drop    = 1'b1; nFlag = 1'b1; end
              OP_SETPERM:  begin strobe.setPerm = 1'b1; nFlag = 1'b1; end
              OP_RSV_SET:  begin strobe.rsvSet  = 1'b1; nFlag = 1'b1; end
              OP_RSV_CLR:  begin strobe.rsvClr  = 1'b1; nFlag = 1'b1; end
              OP_RSV_CHK:  nFlag = wayHeld[matchWay] && (wayCtx[matchWay] == reqCtx);
              default: begin nFlag = 1'b1; nPerm = selPerm; end
            endcase
          end
        end
        default: nError = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspFlag  <= 1'b0;
      rspError <= 1'b0;
      rspWay   <= '0;
      rspAddr  <= '0;
      rspPerm  <= '0;
    end else begin
      rspValid <= reqValid;
      rspFlag  <= nFlag;
      rspError <= nError;
      rspWay   <= nWay;
      rspAddr  <= nAddr;
      rspPerm  <= nPerm;
    end
  end

endmodule

// File: rtl/tag_directory.sv
module tag_directory
  import tagdir_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 6,
  parameter int SETS     = 8,
  parameter int WAYS     = 4,
  parameter int CTX_W    = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic [3:0]               reqOp,
  input  logic [1:0]               reqKind,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [1:0]               reqPerm,
  input  logic [CTX_W-1:0]         reqCtx,
  output logic                     rspValid,
  output logic                     rspFlag,
  output logic                     rspError,
  output logic [$clog2(WAYS)-1:0]  rspWay,
  output logic [ADDR_W-1:0]        rspAddr,
  output logic [1:0]               rspPerm
);

  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - OFFSET_W - SET_W;

  dirStrobe_t        strobe;
  logic [WAY_W-1:0]  wrWay;
  logic [WAYS-1:0]   matchVec, freeVec, wayHeld;
  logic [1:0]        wayPerm [WAYS];
  logic [CTX_W-1:0]  wayCtx  [WAYS];
  logic [WAY_W-1:0]  victimWay;
  logic [TAG_W-1:0]  victimTag;

  tagdir_store #(
    .ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .SETS(SETS), .WAYS(WAYS), .CTX_W(CTX_W)
  ) u_store (
    .clk(clk), .rstN(rstN), .lookAddr(reqAddr), .strobe(strobe), .wrWay(wrWay),
    .newPerm(reqPerm), .newCtx(reqCtx), .matchVec(matchVec), .freeVec(freeVec),
    .wayPerm(wayPerm), .wayHeld(wayHeld), .wayCtx(wayCtx),
    .victimWay(victimWay), .victimTag(victimTag)
  );

  tagdir_ctrl #(
    .ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .SETS(SETS), .WAYS(WAYS), .CTX_W(CTX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqCtx(reqCtx), .matchVec(matchVec), .freeVec(freeVec),
    .wayPerm(wayPerm), .wayHeld(wayHeld), .wayCtx(wayCtx),
    .victimWay(victimWay), .victimTag(victimTag), .strobe(strobe), .wrWay(wrWay),
    .rspValid(rspValid), .rspFlag(rspFlag), .rspError(rspError),
    .rspWay(rspWay), .rspAddr(rspAddr), .rspPerm(rspPerm)
  );

endmodule

// File: rtl/tagdir_checker.sv
module tagdir_checker #(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 6,
  parameter int SETS     = 8,
  parameter int WAYS     = 4
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     reqValid,
  input logic [3:0]               reqOp,
  input logic [ADDR_W-1:0]        reqAddr,
  input logic                     rspValid,
  input logic                     rspFlag,
  input logic                     rspError,
  input logic [$clog2(WAYS)-1:0]  rspWay,
  input logic [ADDR_W-1:0]        rspAddr
);

  localparam int SET_W = $clog2(SETS);

  // R1: every request gets a response on the next cycle
  a_r1_resp_next: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R1: no response without a request
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R13: a refused operation reports no result and way 0
  a_r13_error_clean: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspError) |-> (!rspFlag && rspWay == '0));

  // R10: a probe result is line aligned and lies in the probed set
  a_r10_probe_in_set: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFlag && $past(reqValid) && $past(reqOp) == 4'd6) |->
      (rspAddr[OFFSET_W-1:0] == '0 &&
       rspAddr[OFFSET_W +: SET_W] == $past(reqAddr[OFFSET_W +: SET_W])));

  // R6: a line just allocated is invalid, so an access to it misses
  a_r6_new_line_invalid: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 4'd0 && $past(reqValid) && $past(reqOp) == 4'd3 &&
     $past(reqAddr) == reqAddr && rspFlag) |=> !rspFlag);

  // R9: a permission change drops the reservation
  a_r9_perm_drops_rsv: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 4'd9 && $past(reqValid) && $past(reqOp) == 4'd5 &&
     $past(reqAddr) == reqAddr && rspFlag) |=> !rspFlag);

endmodule

bind tag_directory tagdir_checker #(
  .ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .SETS(SETS), .WAYS(WAYS)
) u_checker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
  .rspValid(rspValid), .rspFlag(rspFlag), .rspError(rspError),
  .rspWay(rspWay), .rspAddr(rspAddr)
);

// File: tb/tag_directory_bench.sv
`timescale 1ns/1ps
module tag_directory_bench;

  localparam int ADDR_W   = 32;
  localparam int OFFSET_W = 6;
  localparam int SETS     = 8;
  localparam int WAYS     = 4;
  localparam int CTX_W    = 4;
  localparam int SET_W    = $clog2(SETS);
  localparam int WAY_W    = $clog2(WAYS);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [3:0]        reqOp = '0;
  logic [1:0]        reqKind = '0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [1:0]        reqPerm = '0;
  logic [CTX_W-1:0]  reqCtx = '0;
  logic              rspValid, rspFlag, rspError;
  logic [WAY_W-1:0]  rspWay;
  logic [ADDR_W-1:0] rspAddr;
  logic [1:0]        rspPerm;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tag_directory #(
    .ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .SETS(SETS), .WAYS(WAYS), .CTX_W(CTX_W)
  ) u_tag_directory (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqPerm(reqPerm), .reqCtx(reqCtx), .rspValid(rspValid),
    .rspFlag(rspFlag), .rspError(rspError), .rspWay(rspWay), .rspAddr(rspAddr),
    .rspPerm(rspPerm)
  );

  // Reference state built from the requirements
  bit mValid [SETS][WAYS];
  int mTag   [SETS][WAYS];
  int mPerm  [SETS][WAYS];
  bit mHeld  [SETS][WAYS];
  int mCtx   [SETS][WAYS];
  int mAge   [SETS][WAYS];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mkAddr(input int tag, input int set);
    return ADDR_W'((tag << (OFFSET_W + SET_W)) | (set << OFFSET_W));
  endfunction

  function automatic string tagOf(input int op);
    case (op)
      0: return "R3";
      1: return "R2";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R9";
      6: return "R10";
      7, 8, 9: return "R8";
      10: return "R9";
      default: return "R1";
    endcase
  endfunction

  task automatic modelReset();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        mValid[s][w] = 0; mTag[s][w] = 0; mPerm[s][w] = 0;
        mHeld[s][w] = 0; mCtx[s][w] = 0; mAge[s][w] = w;
      end
  endtask

  task automatic modelTouch(input int s, input int w);
    int ref_age = mAge[s][w];
    for (int v = 0; v < WAYS; v++) begin
      if (v == w) mAge[s][v] = 0;
      else if (mAge[s][v] < ref_age) mAge[s][v]++;
    end
  endtask

  task automatic model(input int op, input logic [ADDR_W-1:0] addr, input int kind,
                       input int perm, input int ctx, output bit eFlag, output bit eErr,
                       output int eWay, output logic [ADDR_W-1:0] eAddr, output int ePerm);
    int s = int'(addr[OFFSET_W +: SET_W]);
    int t = int'(addr >> (OFFSET_W + SET_W));
    int m = -1;
    int f = -1;
    int vic = 0;
    eFlag = 0; eErr = 0; eWay = 0; eAddr = '0; ePerm = 0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (mValid[s][w] && mTag[s][w] == t && mPerm[s][w] != 0) m = w;
      if (!mValid[s][w] || mPerm[s][w] == 0) f = w;
      if (mAge[s][w] == WAYS - 1) vic = w;
    end
    case (op)
      0: if (m >= 0) begin
           eWay = m;
           eFlag = (mPerm[s][m] == 3) || (mPerm[s][m] == 2 && kind <= 1);
           modelTouch(s, m);
         end
      1: begin eFlag = (m >= 0); eWay = (m >= 0) ? m : 0; end
      2: eFlag = (m >= 0) || (f >= 0);
      3: if (m >= 0 || f < 0) eErr = 1;
         else begin
           mValid[s][f] = 1; mTag[s][f] = t; mPerm[s][f] = 1; mHeld[s][f] = 0;
           modelTouch(s, f);
           eFlag = 1; eWay = f;
         end
      6: if (f >= 0) eErr = 1;
         else begin eFlag = 1; eWay = vic; eAddr = mkAddr(mTag[s][vic], s); end
      4, 5, 7, 8, 9, 10:
         if (m < 0) eErr = 1;
         else begin
           eWay = m;
           eFlag = 1;
           case (op)
             4: begin mValid[s][m] = 0; mPerm[s][m] = 0; mHeld[s][m] = 0; end
             5: begin mPerm[s][m] = perm; mHeld[s][m] = 0; end
             7: begin mHeld[s][m] = 1; mCtx[s][m] = ctx; end
             8: mHeld[s][m] = 0;
             9: eFlag = mHeld[s][m] && (mCtx[s][m] == ctx);
             default: ePerm = mPerm[s][m];
           endcase
         end
      default: eErr = 1;
    endcase
  endtask

  // Drive at the falling edge, sample 1 ns after the following rising edge
  task automatic runOp(input int op, input logic [ADDR_W-1:0] addr, input int kind,
                       input int perm, input int ctx, input string tagOver);
    bit eFlag, eErr;
    int eWay, ePerm;
    logic [ADDR_W-1:0] eAddr;
    string tg;
    tg = (tagOver.len() > 0) ? tagOver : tagOf(op);
    reqValid = 1'b1;
    reqOp = 4'(op); reqAddr = addr; reqKind = 2'(kind);
    reqPerm = 2'(perm); reqCtx = CTX_W'(ctx);
    model(op, addr, kind, perm, ctx, eFlag, eErr, eWay, eAddr, ePerm);
    @(posedge clk);
    #1;
    check(rspValid == 1'b1, "R1", "rspValid", rspValid, 1);
    check(rspFlag == eFlag, tg, $sformatf("flag op%0d", op), rspFlag, eFlag);
    check(rspError == eErr, (op > 10) ? "R1" : "R13", $sformatf("error op%0d", op), rspError, eErr);
    check(int'(rspWay) == eWay, tg, $sformatf("way op%0d", op), rspWay, eWay);
    check(rspAddr == eAddr, tg, $sformatf("addr op%0d", op), rspAddr, eAddr);
    check(int'(rspPerm) == ePerm, tg, $sformatf("perm op%0d", op), rspPerm, ePerm);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int rnd;
    logic [ADDR_W-1:0] a;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11: reset state
    check(rspValid == 1'b0, "R11", "rspValid after reset", rspValid, 0);
    runOp(1, mkAddr(1, 0), 0, 0, 0, "R11");
    runOp(2, mkAddr(1, 0), 0, 0, 0, "R11");
    runOp(6, mkAddr(1, 0), 0, 0, 0, "R10");
    // R6: fill set 0, then one more allocation must be refused
    for (int t = 1; t <= WAYS; t++) runOp(3, mkAddr(t, 0), 0, 0, 0, "R6");
    runOp(3, mkAddr(9, 0), 0, 0, 0, "R6");
    runOp(3, mkAddr(2, 0), 0, 0, 0, "R6");
    runOp(2, mkAddr(9, 0), 0, 0, 0, "R5");
    // R12: another set is unaffected by the full set
    runOp(3, mkAddr(9, 1), 0, 0, 0, "R12");
    runOp(1, mkAddr(1, 1), 0, 0, 0, "R12");
    runOp(6, mkAddr(1, 0), 0, 0, 0, "R10");
    // R3/R4: read-only line refuses a store but the touch still counts
    runOp(5, mkAddr(1, 0), 0, 2, 0, "R9");
    runOp(0, mkAddr(1, 0), 2, 0, 0, "R3");
    runOp(6, mkAddr(1, 0), 0, 0, 0, "R4");
    runOp(0, mkAddr(1, 0), 1, 0, 0, "R3");
    runOp(0, mkAddr(2, 0), 0, 0, 0, "R3");
    runOp(6, mkAddr(1, 0), 0, 0, 0, "R4");
    // R8/R9: reservations and their loss on permission change
    runOp(7, mkAddr(3, 0), 0, 0, 5, "R8");
    runOp(9, mkAddr(3, 0), 0, 0, 5, "R8");
    runOp(9, mkAddr(3, 0), 0, 0, 4, "R8");
    runOp(5, mkAddr(3, 0), 0, 3, 0, "R9");
    runOp(9, mkAddr(3, 0), 0, 0, 5, "R9");
    runOp(10, mkAddr(3, 0), 0, 0, 0, "R9");
    // R2/R5/R6: absent line frees its way, and allocation reuses it
    runOp(5, mkAddr(2, 0), 0, 0, 0, "R2");
    runOp(1, mkAddr(2, 0), 0, 0, 0, "R2");
    runOp(2, mkAddr(9, 0), 0, 0, 0, "R5");
    runOp(3, mkAddr(9, 0), 0, 0, 0, "R6");
    // R7/R13: remove, then line-addressed operations fail
    runOp(4, mkAddr(4, 0), 0, 0, 0, "R7");
    runOp(1, mkAddr(4, 0), 0, 0, 0, "R7");
    runOp(7, mkAddr(4, 0), 0, 0, 1, "R13");
    runOp(12, mkAddr(4, 0), 0, 0, 0, "R1");
    // Constrained random mix over a small pool of tags and sets
    rnd = $urandom(32'd2024);
    for (int i = 0; i < 3000; i++) begin
      int op, setSel;
      op = ($urandom % 100 < 25) ? 3 : int'($urandom % 11);
      setSel = int'($urandom % 3);
      a = mkAddr(int'($urandom % 6), (setSel == 2) ? 7 : setSel);
      runOp(op, a, int'($urandom % 4), int'($urandom % 4), int'($urandom % 4), "");
    end
    reqValid = 1'b0;
    @(posedge clk);
    #1;
    check(rspValid == 1'b0, "R1", "rspValid idle", rspValid, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule